// File: doc/BRIEF.md
# Asymmetric Four-Way Decode Slot Steering

This block sits between a queue of pre-decoded instruction records and a bank of four decoders of unequal capability. Every cycle it looks at the four oldest records and decides how many of them go to a decoder and which decoder each one uses. Every record arrives with two precomputed facts. The first is its micro-op count, where a micro-fused load-plus-operation already counts as one. The second is a flag that marks it as complex. Only the first decoder, slot 0, can produce more than one micro-op or take a complex record. The other three slots take only plain single micro-op records. A cycle's output is limited both by the number of slots and by a cap on the total number of micro-ops.

A record that needs more micro-ops than slot 0 can produce is bound for the microcode sequencer. It takes slot 0 alone and emits a fixed number of setup micro-ops. After a fixed switch delay the block raises a request to the sequencer and holds it until the sequencer reports done. While the switch and the sequencer run, no record is steered. The grant outputs are combinational from the presented window, so the queue pops the granted records at the next clock edge.

Top module: `decode_steer`

## Requirements
- R1: Record k of the window (`in_uops` bits [3k+2:3k] hold its micro-op count, 1 to 7; `in_cplx[k]` is its complex flag; `in_vld[k]` is its presence bit, and the present bits must be contiguous from bit 0) is the k-th oldest. The granted slots always form a prefix of the window, and `in_take` equals the number of granted slots.
- R2: Slot 0 takes any present record of 1 to 4 micro-ops. Slots 1 to 3 take a record only if its count is exactly 1. A record the next slot cannot take ends the cycle, and it is offered again in slot 0 in the following cycle.
- R3: A record with its complex flag set is granted only in slot 0, even when its count is 1.
- R4: At most 4 records and at most 5 micro-ops are granted per cycle. This gives the patterns 4-1, 3-1-1, 2-1-1-1 and 1-1-1-1.
- R5: A stream of two-micro-op records is granted one record per cycle.
- R6: A record with a count above 4 is granted alone in slot 0, with 3 setup micro-ops, and `out_seq_grant` is high in that cycle. Two cycles with no grant and `seq_req` low follow, and `seq_req` is high in the third cycle after the grant.
- R7: While `seq_req` is high, no record is granted and the window is ignored. `seq_req` stays high until a cycle in which `seq_done` is high, and grants resume in the next cycle.
- R8: A high `seq_done` while `seq_req` is low has no effect on grants or on `seq_req`.
- R9: `out_uop_vld` is a thermometer code whose count equals the micro-ops granted. Field i of `out_uop_src` (bits [2i+1:2i]) names the slot that produced micro-op i. Slot 0's micro-ops come first, then one micro-op for each further slot in slot order.
- R10: Out of reset the sequencer request is low and the first presented window is steered at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 4 | Presence bits of the four oldest records |
| in_uops | input | 12 | Micro-op count of each record, 3 bits each |
| in_cplx | input | 4 | Complex flag of each record |
| in_take | output | 3 | Number of records granted this cycle |
| out_grant | output | 4 | Slot k holds record k this cycle |
| out_seq_grant | output | 1 | Slot 0 holds a sequencer-bound record |
| out_uop_vld | output | 5 | Valid micro-op positions, thermometer coded |
| out_uop_src | output | 10 | Producing slot of each micro-op position, 2 bits each |
| seq_req | output | 1 | Request to the microcode sequencer |
| seq_done | input | 1 | Sequencer finished |

## Verification
Grants, `in_take` and the micro-op map depend only on the presented window and the current phase, so they are due in the same cycle the window is driven. The bench drives each window after the falling edge and samples one time unit later. `seq_req` is due three rising edges after the cycle of a sequencer grant and falls one edge after the cycle in which done is seen. The bench keeps its own phase counter, advanced once for each cycle before the rising edge, so each expected value matches the cycle being sampled. Random windows vary in fill level, mix counts and flags, and scatter stray done pulses. Directed runs at the start hit each slot pattern and each cause of a cycle ending early.

// File: rtl/decode_steer.sv
module decode_steer #(
  parameter int NSLOT      = 4,
  parameter int UOP_CAP    = 5,
  parameter int SLOT0_MAX  = 4,
  parameter int CW         = 3,
  parameter int SEQ_SETUP  = 3,
  parameter int SWITCH_DLY = 2,
  localparam int TW   = $clog2(NSLOT + 1),
  localparam int SRCW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSLOT-1:0]          in_vld,
  input  logic [NSLOT*CW-1:0]       in_uops,
  input  logic [NSLOT-1:0]          in_cplx,
  output logic [TW-1:0]             in_take,
  output logic [NSLOT-1:0]          out_grant,
  output logic                      out_seq_grant,
  output logic [UOP_CAP-1:0]        out_uop_vld,
  output logic [UOP_CAP*SRCW-1:0]   out_uop_src,
  output logic                      seq_req,
  input  logic                      seq_done
);

  localparam int DW = $clog2(SWITCH_DLY + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SWITCH, ST_SEQ} st_t;

  st_t           st;
  logic [DW-1:0] sw_cnt;
  int            tot;
  int            u0;
  int            take;

  always_comb begin
    logic go;
    int   uk;
    out_grant     = '0;
    out_seq_grant = 1'b0;
    tot  = 0;
    u0   = 0;
    take = 0;
    go   = (st == ST_IDLE);
    for (int k = 0; k < NSLOT; k++) begin
      uk = int'(in_uops[k*CW +: CW]);
      if (k == 0) begin
        if (go && in_vld[0]) begin
          out_grant[0]  = 1'b1;
          out_seq_grant = (uk > SLOT0_MAX);
          u0   = out_seq_grant ? SEQ_SETUP : uk;
          tot  = u0;
          take = 1;
          go   = !out_seq_grant;
        end else begin
          go = 1'b0;
        end
      end else if (go && in_vld[k] && !in_cplx[k] && uk == 1 && tot < UOP_CAP) begin
        out_grant[k] = 1'b1;
        tot  = tot + 1;
        take = take + 1;
      end else begin
        go = 1'b0;
      end
    end
  end

  assign in_take = TW'(take);

  always_comb begin
    for (int i = 0; i < UOP_CAP; i++) begin
      out_uop_vld[i] = (i < tot);
      if (i < tot && i >= u0)
        out_uop_src[i*SRCW +: SRCW] = SRCW'(i - u0 + 1);
      else
        out_uop_src[i*SRCW +: SRCW] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      sw_cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (out_seq_grant) begin
          st     <= ST_SWITCH;
          sw_cnt <= '0;
        end
        ST_SWITCH: if (sw_cnt == DW'(SWITCH_DLY - 1)) st <= ST_SEQ;
                   else sw_cnt <= sw_cnt + 1'b1;
        ST_SEQ: if (seq_done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign seq_req = (st == ST_SEQ);

endmodule

module decode_steer_chk #(
  parameter int NSLOT   = 4,
  parameter int UOP_CAP = 5,
  parameter int CW      = 3,
  parameter int TW      = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NSLOT-1:0]     in_vld,
  input logic [NSLOT*CW-1:0]  in_uops,
  input logic [NSLOT-1:0]     in_cplx,
  input logic [TW-1:0]        in_take,
  input logic [NSLOT-1:0]     out_grant,
  input logic                 out_seq_grant,
  input logic [UOP_CAP-1:0]   out_uop_vld,
  input logic                 seq_req,
  input logic                 seq_done
);

  p_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(in_take) == $countones(out_grant));

  p_prefix_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((({1'b0, out_grant} + 1'b1) & {1'b0, out_grant}) == '0));

  p_present_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_grant & ~in_vld) == '0));

  for (genvar k = 1; k < NSLOT; k++) begin : g_side
    p_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_grant[k] |-> (in_uops[k*CW +: CW] == CW'(1)));
    p_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_grant[k] |-> !in_cplx[k]);
  end

  p_uops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_uop_vld) >= $countones(out_grant));

  p_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_seq_grant |-> (out_grant == NSLOT'(1)));

  p_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_seq_grant |=> (!seq_req && out_grant == '0));

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req |-> (out_grant == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_req && !seq_done) |=> seq_req);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_req && seq_done) |=> !seq_req);

endmodule

bind decode_steer decode_steer_chk #(
  .NSLOT(NSLOT), .UOP_CAP(UOP_CAP), .CW(CW), .TW(TW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_uops(in_uops),
  .in_cplx(in_cplx), .in_take(in_take), .out_grant(out_grant),
  .out_seq_grant(out_seq_grant), .out_uop_vld(out_uop_vld),
  .seq_req(seq_req), .seq_done(seq_done)
);

// File: tb/decode_steer_tb.sv
module decode_steer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CAP   = 5;
  localparam int SETUP = 3;
  localparam int QN    = 3000;
  localparam int MAXC  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  in_vld = '0;
  logic [11:0] in_uops = '0;
  logic [3:0]  in_cplx = '0;
  logic [2:0]  in_take;
  logic [3:0]  out_grant;
  logic        out_seq_grant;
  logic [4:0]  out_uop_vld;
  logic [9:0]  out_uop_src;
  logic        seq_req;
  logic        seq_done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  decode_steer u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_uops(in_uops),
    .in_cplx(in_cplx), .in_take(in_take), .out_grant(out_grant),
    .out_seq_grant(out_seq_grant), .out_uop_vld(out_uop_vld),
    .out_uop_src(out_uop_src), .seq_req(seq_req), .seq_done(seq_done)
  );

  int q_u[QN];
  bit q_c[QN];
  int errs = 0, checks = 0;
  int dir_len;
  int ptr, phase, sw, waitc, nv, g, n, tot, u0, cyc, r;
  bit sq, stray, prev_stray;
  int wu[4];
  bit wc[4];
  string why, tag;
  logic [9:0] exp_src, act_src;

  task automatic chk(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  function automatic void model(input int nvv, input int u[4], input bit c[4],
                                output int gg, output int nn, output int tt,
                                output int uu0, output bit ss, output string wy);
    gg = 0; nn = 0; tt = 0; uu0 = 0; ss = 0; wy = "R1";
    if (nvv > 0) begin
      ss  = u[0] > 4;
      uu0 = ss ? SETUP : u[0];
      tt  = uu0; nn = 1; gg = 1;
      if (ss) wy = "R6";
      else if (u[0] == 2 && nvv > 1 && u[1] == 2) wy = "R5";
      if (!ss) begin
        for (int k = 1; k < 4; k++) begin
          if (k >= nvv) break;
          if (c[k]) begin wy = "R3"; break; end
          if (u[k] != 1) begin if (wy != "R5") wy = "R2"; break; end
          if (tt >= CAP) begin wy = "R4"; break; end
          nn++; tt++; gg |= (1 << k);
        end
      end
    end
  endfunction

  task automatic push(input int u, input bit c);
    q_u[dir_len] = u; q_c[dir_len] = c; dir_len++;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    r = $urandom(2718);
    dir_len = 0;
    push(4,0); push(1,0); push(1,0);
    push(3,0); push(1,0); push(1,0); push(1,0);
    push(2,0); push(1,0); push(1,0); push(1,0); push(1,0);
    push(1,0); push(1,0); push(1,0); push(1,0);
    push(2,0); push(2,0); push(2,0); push(2,0);
    push(1,0); push(1,1); push(1,0); push(1,0);
    push(3,1); push(1,0);
    push(6,0); push(1,0);
    push(1,0); push(2,0); push(1,0);
    push(7,0); push(3,0); push(3,0);
    for (int i = dir_len; i < QN; i++) begin
      r = $urandom_range(0, 99);
      q_u[i] = r < 60 ? 1 : r < 75 ? 2 : r < 85 ? 3 : r < 94 ? 4 : $urandom_range(5, 7);
      q_c[i] = ($urandom_range(0, 9) == 0);
    end

    in_vld = 4'b1111; in_uops = {4{3'd1}}; seq_done = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "seq_req in reset", int'(seq_req), 0);
    @(negedge clk);
    rst_n = 1'b1; seq_done = 1'b0;

    ptr = 0; phase = 0; sw = 0; waitc = 0; prev_stray = 0; cyc = 0;
    while ((ptr < QN || phase != 0) && cyc < MAXC) begin
      if (cyc > 0) @(negedge clk);
      if (phase == 0) begin
        if (ptr < dir_len) nv = 4;
        else begin r = $urandom_range(0, 6); nv = r > 4 ? 4 : r; end
        if (nv > QN - ptr) nv = QN - ptr;
        for (int k = 0; k < 4; k++) begin
          if (k < nv) begin wu[k] = q_u[ptr+k]; wc[k] = q_c[ptr+k]; end
          else begin wu[k] = $urandom_range(1, 7); wc[k] = 1'($urandom_range(0, 1)); end
        end
        in_vld = 4'((1 << nv) - 1);
      end else begin
        for (int k = 0; k < 4; k++) begin
          wu[k] = $urandom_range(1, 7); wc[k] = 1'($urandom_range(0, 1));
        end
        in_vld = 4'($urandom_range(0, 15));
        nv = 0;
      end
      for (int k = 0; k < 4; k++) begin
        in_uops[k*3 +: 3] = 3'(wu[k]);
        in_cplx[k] = wc[k];
      end
      stray = (phase != 2) && ($urandom_range(0, 3) == 0);
      seq_done = (phase == 2) ? (waitc == 0) : stray;
      #1;
      if (phase == 0) model(nv, wu, wc, g, n, tot, u0, sq, why);
      else begin g = 0; n = 0; tot = 0; u0 = 0; sq = 0; why = "R7"; end
      tag = (cyc == 0) ? "R10" : why;
      chk(tag, "grant", int'(out_grant), g);
      chk(tag, "take", int'(in_take), n);
      chk("R6", "seq_grant", int'(out_seq_grant), int'(sq));
      chk("R9", "uop_vld", int'(out_uop_vld), (1 << tot) - 1);
      exp_src = '0; act_src = '0;
      for (int i = 0; i < tot; i++) begin
        exp_src[i*2 +: 2] = (i < u0) ? 2'd0 : 2'(i - u0 + 1);
        act_src[i*2 +: 2] = out_uop_src[i*2 +: 2];
      end
      chk("R9", "uop_src", int'(act_src), int'(exp_src));
      chk(prev_stray ? "R8" : (phase == 1 ? "R6" : "R7"), "seq_req",
          int'(seq_req), int'(phase == 2));
      prev_stray = stray;
      ptr += n;
      case (phase)
        0: if (sq) begin phase = 1; sw = 0; end
        1: if (sw == 1) begin phase = 2; waitc = $urandom_range(0, 4); end
           else sw++;
        default: if (waitc == 0) phase = 0; else waitc--;
      endcase
      cyc++;
    end
    chk("R1", "records drained", ptr, QN);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule